// File: doc/BRIEF.md
# Trimmed One-Second Divider

This block turns an oscillator-rate enable (nominally 32768 pulses per second) into a one-second tick and applies a signed digital trim so that a slow or fast crystal still keeps correct time on average. The trim works on a 64-minute cycle. In each of the first 2×N minutes of that cycle (N is the five-bit trim magnitude), the first second is made shorter or longer. The length change is a multiple of the 256-count stage of the divider. A positive trim shortens that second by 256 oscillator counts. A negative trim lengthens it by 128 counts. Over two minutes one step therefore gains 512 counts or loses 256.

A separate counter produces the divider taps that feed a square-wave generator. This counter is never trimmed, so changing the trim value cannot move a square-wave frequency. A clear strobe, raised when a clock register write completes, restarts the divider chain. A stop input freezes every stage, and counting resumes from the frozen values when stop is released. The position inside the 64-minute cycle comes from the block's own second ticks and is exported as a minute index.

Top module: `caltrim_divider`

## Requirements
- R1: While reset is asserted, and after it is released with no enables, taps, min_idx and sec_tick are all zero.
- R2: taps rises by one for each accepted enable (osc_en high, stop low, div_clr low) and wraps at 2^DIV_W. The trim inputs never affect it.
- R3: An unaltered second lasts exactly 2^DIV_W accepted enables. sec_tick is high for one clock, in the clock after the edge that takes the final enable of the second.
- R4: With cal_sign = 1 (speed up), an altered second lasts 2^DIV_W − 2^STAGE_W enables.
- R5: With cal_sign = 0 (slow down), an altered second lasts 2^DIV_W + 2^(STAGE_W−1) enables.
- R6: A second is altered only when it is second 0 of a minute whose index is below 2×cal_mag. A magnitude of 0 alters nothing, and minutes 62 and 63 are never altered.
- R7: min_idx counts completed minutes of SEC_PER_MIN ticks, modulo 64, and changes only on a tick.
- R8: div_clr clears taps and the count within the current second, taking priority over stop and osc_en. It leaves min_idx and the second-of-minute position unchanged.
- R9: While stop is high (and div_clr low) no divider state changes. After stop falls, counting continues from the frozen values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | One pulse per oscillator period |
| div_clr | input | 1 | Divider chain clear strobe |
| stop | input | 1 | Freezes all divider stages while high |
| cal_sign | input | 1 | Trim direction: 1 shortens, 0 lengthens |
| cal_mag | input | MAG_W | Trim magnitude N; minutes 0..2N−1 are altered |
| sec_tick | output | 1 | One-clock pulse per completed second |
| taps | output | DIV_W | Untrimmed divider taps |
| min_idx | output | CYC_W | Minute position in the 64-minute trim cycle |

## Verification
The bench builds the block with DIV_W = 6, STAGE_W = 3 and SEC_PER_MIN = 4. A second is then 64 enables, a shortened one 56 and a lengthened one 68, and a minute lasts only four ticks. With these values the full 64-minute cycle, including the never-altered minutes 62 and 63 and the wrap back to minute 0 at magnitude 31, fits in about sixteen thousand clocks. The trim widths and the 64-minute cycle keep their default sizes, so the magnitude-to-window rule is tested at its real bounds.

// File: rtl/caltrim_pkg.sv
package caltrim_pkg;

  // Kind of the second currently being counted.
  typedef enum logic [1:0] {
    SEC_PLAIN = 2'd0,
    SEC_SHORT = 2'd1,
    SEC_LONG  = 2'd2
  } sec_kind_e;

endpackage

// File: rtl/caltrim_rst_sync.sv
module caltrim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_s = hold_q;

endmodule

// File: rtl/caltrim_taps.sv
module caltrim_taps #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [DIV_W-1:0] taps
);

  logic [DIV_W-1:0] tap_q;
  logic [DIV_W-1:0] tap_d;

  always_comb begin
    tap_d = tap_q;
    if (clr)      tap_d = '0;
    else if (run) tap_d = tap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_d;
  end

  assign taps = tap_q;

  // R8: a clear strobe empties the tap counter on the next edge
  a_r8_taps_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap_q == '0));

  // R9: without an accepted enable the taps hold
  a_r9_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run) |=> $stable(tap_q));

endmodule

// File: rtl/caltrim_second.sv
module caltrim_second
  import caltrim_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int STAGE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  input  logic alter,
  input  logic sign,
  output logic fire,
  output logic sec_tick
);

  localparam int CNT_W     = DIV_W + 1;
  localparam int BASE_LEN  = 1 << DIV_W;
  localparam int SHORT_LEN = BASE_LEN - (1 << STAGE_W);
  localparam int LONG_LEN  = BASE_LEN + (1 << (STAGE_W - 1));
  localparam logic [CNT_W-1:0] TERM_PLAIN = CNT_W'(BASE_LEN - 1);
  localparam logic [CNT_W-1:0] TERM_SHORT = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] TERM_LONG  = CNT_W'(LONG_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             tick_q;
  sec_kind_e        kind;
  logic [CNT_W-1:0] term;

  always_comb begin
    if (!alter)    kind = SEC_PLAIN;
    else if (sign) kind = SEC_SHORT;
    else           kind = SEC_LONG;
  end

  always_comb begin
    case (kind)
      SEC_SHORT: term = TERM_SHORT;
      SEC_LONG:  term = TERM_LONG;
      default:   term = TERM_PLAIN;
    endcase
  end

  assign fire = step && !clr && (cnt_q >= term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (fire) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= fire;
    end
  end

  assign sec_tick = tick_q;

  // R3: the tick is a single-clock pulse
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R5: the count never passes the longest allowed second
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LONG_LEN));

  // R4: a shortened second ends at its reduced length
  a_r4_short_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && alter && sign && cnt_q == TERM_SHORT) |=> sec_tick);

  // R8: after a clear no tick follows on the next edge
  a_r8_clear_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ##1 !sec_tick);

endmodule

// File: rtl/caltrim_cycle.sv
module caltrim_cycle #(
  parameter int SEC_PER_MIN = 60,
  parameter int CYC_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [MAG_W-1:0] mag,
  output logic             alter,
  output logic [CYC_W-1:0] min_idx
);

  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int CMP_W = (CYC_W > MAG_W + 1) ? CYC_W : MAG_W + 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] sec_d;
  logic [CYC_W-1:0] min_q;
  logic [CYC_W-1:0] min_d;
  logic [CMP_W-1:0] window;
  logic             min_end;

  assign window  = CMP_W'({mag, 1'b0});
  assign min_end = (sec_q == SEC_LAST);
  assign alter   = (sec_q == '0) && (CMP_W'(min_q) < window);

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    if (adv) begin
      if (min_end) begin
        sec_d = '0;
        min_d = min_q + 1'b1;
      end else begin
        sec_d = sec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
    end
  end

  assign min_idx = min_q;

  // R7: the minute index moves only with a completed second
  a_r7_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(min_q));

  // R7: the cycle wraps from its last minute to zero
  a_r7_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && min_end && min_q == {CYC_W{1'b1}}) |=> (min_q == '0));

  // R6: the final minute of the cycle is never trimmed
  a_r6_last_min_plain: assert property (@(posedge clk) disable iff (!rst_n)
    alter |-> (min_q != {CYC_W{1'b1}}));

endmodule

// File: rtl/caltrim_divider.sv
module caltrim_divider #(
  parameter int DIV_W       = 15,
  parameter int STAGE_W     = 8,
  parameter int SEC_PER_MIN = 60,
  parameter int CYC_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             div_clr,
  input  logic             stop,
  input  logic             cal_sign,
  input  logic [MAG_W-1:0] cal_mag,
  output logic             sec_tick,
  output logic [DIV_W-1:0] taps,
  output logic [CYC_W-1:0] min_idx
);

  logic rst_n_s;
  logic step;
  logic alter;
  logic fire;

  assign step = osc_en && !stop;

  caltrim_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  caltrim_taps #(.DIV_W(DIV_W)) u_taps (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (step),
    .clr   (div_clr),
    .taps  (taps)
  );

  caltrim_second #(.DIV_W(DIV_W), .STAGE_W(STAGE_W)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step     (step),
    .clr      (div_clr),
    .alter    (alter),
    .sign     (cal_sign),
    .fire     (fire),
    .sec_tick (sec_tick)
  );

  caltrim_cycle #(.SEC_PER_MIN(SEC_PER_MIN), .CYC_W(CYC_W), .MAG_W(MAG_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .adv     (fire),
    .mag     (cal_mag),
    .alter   (alter),
    .min_idx (min_idx)
  );

  // R9: while stopped, the minute index and tick stay quiet
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stop && !div_clr) |=> (!sec_tick && $stable(min_idx)));

endmodule

// File: tb/caltrim_divider_bench.sv
`timescale 1ns/1ps
module caltrim_divider_bench;

  localparam int DIV_W = 6;
  localparam int STAGE_W = 3;
  localparam int SPM = 4;
  localparam int CYC_W = 6;
  localparam int MAG_W = 5;
  localparam int TAPN = 1 << DIV_W;
  localparam int NMIN = 1 << CYC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0;
  logic div_clr = 1'b0;
  logic stop = 1'b0;
  logic cal_sign = 1'b0;
  logic [MAG_W-1:0] cal_mag = '0;
  logic sec_tick;
  logic [DIV_W-1:0] taps;
  logic [CYC_W-1:0] min_idx;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit chk_on = 0;
  bit cap_on = 0;
  int lens[$];
  int tot = 0;
  int last_tot = 0;

  int m_tap, m_cnt, m_sec, m_min, m_len;
  bit m_tick;
  string m_tag = "R3";

  always #2.5 clk = ~clk;

  caltrim_divider #(.DIV_W(DIV_W), .STAGE_W(STAGE_W), .SEC_PER_MIN(SPM),
                    .CYC_W(CYC_W), .MAG_W(MAG_W)) u_caltrim_divider (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .div_clr(div_clr), .stop(stop),
    .cal_sign(cal_sign), .cal_mag(cal_mag), .sec_tick(sec_tick), .taps(taps),
    .min_idx(min_idx));

  function automatic int exp_len(int mn, int sc, bit sg, int mg);
    if (sc == 0 && mn < 2 * mg) return sg ? TAPN - (1 << STAGE_W) : TAPN + (1 << (STAGE_W - 1));
    return TAPN;
  endfunction

  function automatic string tag_of(int mn, int sc, bit sg, int mg);
    if (sc == 0 && mn < 2 * mg) return sg ? "R4" : "R5";
    if (mg != 0 && sc == 0) return "R6";
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_tap = 0; m_cnt = 0; m_sec = 0; m_min = 0; m_tick = 0; tot = 0;
    end else begin
      m_tick = 0;
      if (div_clr) begin
        m_tap = 0; m_cnt = 0;
      end else if (osc_en && !stop) begin
        tot++;
        m_len = exp_len(m_min, m_sec, cal_sign, cal_mag);
        m_tag = tag_of(m_min, m_sec, cal_sign, cal_mag);
        m_tap = (m_tap + 1) % TAPN;
        if (m_cnt + 1 >= m_len) begin
          m_cnt = 0; m_tick = 1; m_sec++;
          if (m_sec == SPM) begin m_sec = 0; m_min = (m_min + 1) % NMIN; end
        end else m_cnt++;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(taps == DIV_W'(m_tap), "R2 taps", taps, m_tap);
      check(sec_tick == m_tick, {m_tag, " tick"}, sec_tick, m_tick);
      check(min_idx == CYC_W'(m_min), "R7 min_idx", min_idx, m_min);
    end
    if (sec_tick && cap_on) begin
      lens.push_back(tot - last_tot);
      last_tot = tot;
    end
  end

  task automatic do_reset(bit sg, int mg);
    rst_n = 0; osc_en = 0; div_clr = 0; stop = 0;
    cal_sign = sg; cal_mag = MAG_W'(mg);
    cap_on = 0;
    repeat (3) @(negedge clk);
    check(taps == 0 && min_idx == 0 && sec_tick == 0, "R1 reset state",
          int'(taps) + int'(min_idx) + int'(sec_tick), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(taps == 0 && min_idx == 0, "R1 after release", int'(taps) + int'(min_idx), 0);
    lens.delete(); last_tot = 0;
    chk_on = 1; cap_on = 1;
  endtask

  task automatic run_secs(int n);
    while (lens.size() < n) @(negedge clk);
  endtask

  task automatic check_lens(int n, bit sg, int mg);
    for (int k = 0; k < n; k++) begin
      int mn = (k / SPM) % NMIN;
      int sc = k % SPM;
      check(lens[k] == exp_len(mn, sc, sg, mg), tag_of(mn, sc, sg, mg),
            lens[k], exp_len(mn, sc, sg, mg));
    end
  endtask

  initial begin
    // untrimmed seconds, R3 and R7
    do_reset(1'b1, 0);
    osc_en = 1;
    run_secs(9);
    check_lens(9, 1'b1, 0);
    check(min_idx == 2, "R7 two minutes", min_idx, 2);

    // speed-up by one step, R4 and R6
    do_reset(1'b1, 1);
    osc_en = 1;
    run_secs(13);
    check_lens(13, 1'b1, 1);

    // slow-down by two steps, R5
    do_reset(1'b0, 2);
    osc_en = 1;
    run_secs(20);
    check_lens(20, 1'b0, 2);

    // full cycle at magnitude 31, R6 and R7 wrap
    do_reset(1'b1, 31);
    osc_en = 1;
    run_secs(NMIN * SPM + 2);
    check_lens(NMIN * SPM + 2, 1'b1, 31);
    check(lens[62 * SPM] == TAPN, "R6 minute 62 plain", lens[62 * SPM], TAPN);
    check(lens[63 * SPM] == TAPN, "R6 minute 63 plain", lens[63 * SPM], TAPN);
    check(lens[NMIN * SPM] == TAPN - 8, "R6 wrap to minute 0", lens[NMIN * SPM], TAPN - 8);

    // taps ignore the trim, R2
    do_reset(1'b1, 31);
    osc_en = 1;
    repeat (37) @(negedge clk);
    osc_en = 0;
    @(negedge clk);
    check(taps == 37, "R2 taps after 37 enables", taps, 37);

    // stop freeze, R9
    osc_en = 1; stop = 1;
    repeat (10) @(negedge clk);
    check(taps == 37, "R9 taps frozen", taps, 37);
    stop = 0;
    repeat (3) @(negedge clk);
    check(taps == 40, "R9 resume", taps, 40);

    // clear strobe priority, R8
    run_secs(2);
    stop = 1; div_clr = 1;
    @(negedge clk);
    div_clr = 0; stop = 0;
    check(taps == 0, "R8 taps cleared", taps, 0);
    check(min_idx == 0, "R8 minute kept", min_idx, 0);

    // irregular enables with changing trim, compared by the model
    for (int i = 0; i < 6000; i++) begin
      osc_en = ((i * 7) % 5) != 0;
      stop = (i % 997) < 9;
      div_clr = (i % 1409) == 700;
      if (i % 1500 == 0) begin cal_sign = ~cal_sign; cal_mag = MAG_W'((i / 300) % 32); end
      @(negedge clk);
    end
    osc_en = 0; stop = 0; div_clr = 0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule